// File: doc/BRIEF.md
# Strobe Watchdog with Early-Warning Pulse

This block supervises a software heartbeat. A processor toggles a strobe line, and each edge restarts a cycle counter. If a full timeout period passes with no edge, the block drives an active-low warning pulse of fixed width. On the next clock it drops an active-low fault line. The fault line stays low until the strobe moves again. If the strobe stays silent, the warning pulse repeats once per timeout period while the fault stays low. An external flop clocked by the warning pulse and fed by the fault line can therefore latch two consecutive misses.

The strobe has a third state, "left floating". An upstream detector reports this state as a separate digital flag. A floating strobe disables the watchdog. So do a system-reset request, battery-backup operation and a manual reset. While disabled, both outputs are high and the counter is held at zero.

The timeout is either a fixed default number of cycles or a configuration value times a unit cycle count. The configuration value is clamped to a supported range. The choice is sampled while the watchdog is disabled and held while it counts.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it rises, `warn_n` and `fault_n` are both 1.
- R2: The raw strobe passes through a two-flop synchronizer. Either a rising or a falling edge, once seen after synchronization, restarts the timeout count from zero. A strobe that toggles more often than the timeout produces no warning.
- R3: The counter counts enabled cycles. If no edge occurs within the limit L, it expires in the cycle where the count reaches L-1. `warn_n` goes low on the next clock and stays low for exactly PULSE_CYC cycles.
- R4: `fault_n` falls one clock after `warn_n` falls. It stays low until a synchronized strobe edge is seen or the watchdog is disabled. It never rises for any other reason.
- R5: With `fault_n` low and no strobe edge, a further warning pulse follows every L cycles while `fault_n` stays low.
- R6: `sys_rst_i`=1, `batt_mode_i`=1 or a synchronized `strobe_open_i`=1 disables the watchdog. Both outputs go high on the next clock and the counter clears. Counting restarts from zero when the disable ends.
- R7: `man_rst_i`=1 clears the counter and sets both outputs high, in the same way as the other disable conditions.
- R8: With `tsel_i`=0 the limit is DEF_CYC cycles. With `tsel_i`=1 it is clamp(`tcfg_i`, CFG_LO, CFG_HI) × UNIT_CYC cycles. The defaults are 96, 5, 100 and 4.
- R9: The limit is captured from `tsel_i`/`tcfg_i` on every disabled cycle and held while enabled. Changing these inputs mid-count has no effect on the running period.
- R10: A strobe pulse one clock wide restarts the count, the same as a level change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Raw heartbeat strobe (asynchronous) |
| strobe_open_i | input | 1 | Strobe-floating flag (asynchronous, 1 = floating) |
| sys_rst_i | input | 1 | System reset asserted, disables the watchdog |
| batt_mode_i | input | 1 | Battery-backup operation, disables the watchdog |
| man_rst_i | input | 1 | Manual reset, clears timer and sets outputs high |
| tsel_i | input | 1 | 0 = default timeout, 1 = configured timeout |
| tcfg_i | input | CFG_W | Timeout configuration value in units |
| warn_n_o | output | 1 | Active-low early-warning pulse |
| fault_n_o | output | 1 | Active-low latched watchdog fault |

## Verification
The assertions assume that `sys_rst_i`, `batt_mode_i`, `man_rst_i`, `tsel_i` and `tcfg_i` are synchronous to `clk`. Only the strobe and the floating flag may change freely. The assertions also assume that every reachable limit exceeds the warning width by at least two cycles, so pulses never overlap. The stimulus changes every input on the falling clock edge and keeps the configuration inside the 7-bit field. The clamped minimum limit (20 cycles) stays above the 6-cycle pulse. Mid-count configuration changes are made only to show that they are ignored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Timeout limit in clock cycles for a given selection and configuration.
  function automatic int unsigned wdt_limit(input logic sel,
                                            input int unsigned cfg,
                                            input int unsigned def_cyc,
                                            input int unsigned unit_cyc,
                                            input int unsigned cfg_lo,
                                            input int unsigned cfg_hi);
    int unsigned c;
    if (!sel) return def_cyc;
    c = cfg;
    if (c < cfg_lo) c = cfg_lo;
    if (c > cfg_hi) c = cfg_hi;
    return c * unit_cyc;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic open_i,
  output logic edge_pulse,
  output logic open_q
);
  logic [STAGES:0]   s_q;
  logic [STAGES-1:0] o_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      o_q <= '1;
    end else begin
      s_q <= {s_q[STAGES-1:0], strobe_i};
      o_q <= {o_q[STAGES-2:0], open_i};
    end
  end

  // Either edge of the synchronized strobe counts as activity
  assign edge_pulse = s_q[STAGES] ^ s_q[STAGES-1];
  assign open_q     = o_q[STAGES-1];

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned LIM_W   = 9,
  parameter int unsigned RST_LIM = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis,
  input  logic             edge_pulse,
  input  logic [LIM_W-1:0] lim_next,
  output logic             expire
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic             at_end;

  assign at_end = (cnt_q == lim_q - LIM_W'(1));
  assign expire = !dis && !edge_pulse && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= LIM_W'(RST_LIM);
    end else if (dis) begin
      cnt_q <= '0;
      lim_q <= lim_next;
    end else if (edge_pulse || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + LIM_W'(1);
    end
  end

  AST_CNT_BELOW_LIM: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < lim_q); // R3
  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) edge_pulse |=> cnt_q == '0); // R2
  AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) dis |=> cnt_q == '0); // R6
  AST_LIM_HELD: assert property (@(posedge clk) disable iff (!rst_n) !dis |=> $stable(lim_q)); // R9

endmodule

// File: rtl/wdt_outs.sv
module wdt_outs #(
  parameter int unsigned PULSE_CYC = 6,
  parameter int unsigned PW        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic edge_pulse,
  input  logic expire,
  output logic warn_n,
  output logic fault_n
);
  logic [PW-1:0] pcnt_q;
  logic          exp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_n  <= 1'b1;
      fault_n <= 1'b1;
      pcnt_q  <= '0;
      exp_d   <= 1'b0;
    end else begin
      exp_d <= expire;
      if (dis) begin
        warn_n <= 1'b1;
        pcnt_q <= '0;
      end else if (expire) begin
        warn_n <= 1'b0;
        pcnt_q <= PW'(PULSE_CYC - 1);
      end else if (pcnt_q != '0) begin
        pcnt_q <= pcnt_q - PW'(1);
      end else begin
        warn_n <= 1'b1;
      end
      if (dis || edge_pulse) fault_n <= 1'b1;
      else if (exp_d)        fault_n <= 1'b0;
    end
  end

  AST_DIS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) dis |=> warn_n && fault_n); // R6
  AST_FAULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(warn_n) && !dis && !edge_pulse) |=> !fault_n); // R4
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !dis && !edge_pulse) |=> !fault_n); // R4
  AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(dis || edge_pulse)); // R4
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n) pcnt_q < PW'(PULSE_CYC)); // R3
  AST_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && expire) |=> !warn_n && !fault_n); // R5

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned CFG_W     = 7,
  parameter int unsigned DEF_CYC   = 96,
  parameter int unsigned UNIT_CYC  = 4,
  parameter int unsigned CFG_LO    = 5,
  parameter int unsigned CFG_HI    = 100,
  parameter int unsigned PULSE_CYC = 6,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             strobe_open_i,
  input  logic             sys_rst_i,
  input  logic             batt_mode_i,
  input  logic             man_rst_i,
  input  logic             tsel_i,
  input  logic [CFG_W-1:0] tcfg_i,
  output logic             warn_n_o,
  output logic             fault_n_o
);
  import wdt_pkg::*;

  localparam int unsigned MAX_LIM = max_u(DEF_CYC, CFG_HI * UNIT_CYC);
  localparam int unsigned LIM_W   = $clog2(MAX_LIM + 1);
  localparam int unsigned PW      = $clog2(PULSE_CYC + 1);

  logic             edge_pulse;
  logic             open_q;
  logic             dis;
  logic             expire;
  logic [LIM_W-1:0] lim_next;

  wdt_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .open_i(strobe_open_i),
    .edge_pulse(edge_pulse), .open_q(open_q)
  );

  assign dis = sys_rst_i | batt_mode_i | man_rst_i | open_q;

  assign lim_next = LIM_W'(wdt_limit(tsel_i, {{(32-CFG_W){1'b0}}, tcfg_i},
                                     DEF_CYC, UNIT_CYC, CFG_LO, CFG_HI));

  wdt_timer #(.LIM_W(LIM_W), .RST_LIM(DEF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .dis(dis), .edge_pulse(edge_pulse),
    .lim_next(lim_next), .expire(expire)
  );

  wdt_outs #(.PULSE_CYC(PULSE_CYC), .PW(PW)) u_outs (
    .clk(clk), .rst_n(rst_n), .dis(dis), .edge_pulse(edge_pulse),
    .expire(expire), .warn_n(warn_n_o), .fault_n(fault_n_o)
  );

  AST_NO_EXPIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (man_rst_i || open_q) |=> warn_n_o); // R7
  AST_LIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_next >= LIM_W'(PULSE_CYC + 2)); // R8

endmodule

// File: tb/tb_strobe_watchdog.sv
module tb_strobe_watchdog;
  localparam int DEF = 96, UNIT = 4, LO = 5, HI = 100, PCYC = 6, CW = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, strobe = 1'b0, sopen = 1'b0, srst = 1'b1, batt = 1'b0, mr = 1'b0, tsel = 1'b0;
  logic [CW-1:0] tcfg = '0;
  logic warn_n, fault_n;

  strobe_watchdog #(.CFG_W(CW), .DEF_CYC(DEF), .UNIT_CYC(UNIT), .CFG_LO(LO),
                    .CFG_HI(HI), .PULSE_CYC(PCYC), .SYNC_STG(2)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .strobe_open_i(sopen),
    .sys_rst_i(srst), .batt_mode_i(batt), .man_rst_i(mr), .tsel_i(tsel),
    .tcfg_i(tcfg), .warn_n_o(warn_n), .fault_n_o(fault_n)
  );

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  function automatic int ref_limit(bit sel, int cfg);
    if (sel == 1'b0) return DEF;
    return ((cfg < LO) ? LO : (cfg > HI) ? HI : cfg) * UNIT;
  endfunction

  // Behavioural reference: history of samples plus idle-cycle count
  bit m_hist[$] = '{0, 0, 0};
  bit m_open[$] = '{1, 1};
  int m_idle = 0, m_lim = DEF, m_low = 0;
  bit m_wn = 1, m_fn = 1, m_prev_exp = 0;

  always @(posedge clk) begin : ref_model
    bit act, off, fire;
    if (!rst_n) begin
      m_hist = '{0, 0, 0}; m_open = '{1, 1};
      m_idle = 0; m_lim = DEF; m_low = 0; m_wn = 1; m_fn = 1; m_prev_exp = 0;
    end else begin
      act  = m_hist[1] != m_hist[2];
      off  = srst || batt || mr || m_open[1];
      fire = !off && !act && (m_idle + 1 == m_lim);
      if (off) begin m_wn = 1; m_low = 0; end
      else if (fire) begin m_wn = 0; m_low = PCYC - 1; end
      else if (m_low > 0) m_low = m_low - 1;
      else m_wn = 1;
      if (off || act) m_fn = 1;
      else if (m_prev_exp) m_fn = 0;
      m_prev_exp = fire;
      if (off) begin m_idle = 0; m_lim = ref_limit(tsel, int'(tcfg)); end
      else if (act || fire) m_idle = 0;
      else m_idle = m_idle + 1;
      m_hist.push_front(strobe); void'(m_hist.pop_back());
      m_open.push_front(sopen);  void'(m_open.pop_back());
    end
  end

  always @(negedge clk) begin
    checks++;
    if (warn_n !== m_wn) begin
      errors++;
      $display("FAIL %s warn_n actual %b expected %b at %0t", req, warn_n, m_wn, $time);
    end
    checks++;
    if (fault_n !== m_fn) begin
      errors++;
      $display("FAIL %s fault_n actual %b expected %b at %0t", req, fault_n, m_fn, $time);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_every(int per, int total);
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i % per == per - 1) strobe = ~strobe;
    end
  endtask

  task automatic one_clk_pulses(int per, int total);
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      strobe = (i % per == per - 1);
    end
    strobe = 1'b0;
  endtask

  task automatic expect_level(string r, logic act, logic exp, string nm);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", r, nm, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in phase %s", req);
      finish_run();
    end
  end

  initial begin
    req = "R1"; idle(5);
    expect_level("R1", warn_n, 1'b1, "warn_n in reset");
    expect_level("R1", fault_n, 1'b1, "fault_n in reset");
    rst_n = 1'b1; idle(5);
    expect_level("R1", warn_n, 1'b1, "warn_n after reset");
    srst = 1'b0;
    req = "R2";  toggle_every(30, 400);
    expect_level("R2", warn_n, 1'b1, "warn_n with live strobe");
    req = "R3";  idle(DEF + 20);
    expect_level("R4", fault_n, 1'b0, "fault_n after timeout");
    req = "R5";  idle(DEF + 20);
    expect_level("R5", fault_n, 1'b0, "fault_n after second timeout");
    req = "R4";  strobe = ~strobe; idle(10);
    expect_level("R4", fault_n, 1'b1, "fault_n after strobe edge");
    req = "R10"; one_clk_pulses(50, 300);
    req = "R6";  idle(DEF + 10); batt = 1'b1; idle(10); batt = 1'b0; idle(DEF + 20);
    sopen = 1'b1; idle(DEF + 30); sopen = 1'b0; idle(50);
    srst = 1'b1; idle(8); srst = 1'b0; idle(DEF + 20);
    req = "R7";  idle(40); mr = 1'b1; idle(3); mr = 1'b0; idle(DEF + 20);
    mr = 1'b1; idle(2);
    expect_level("R7", fault_n, 1'b1, "fault_n under manual reset");
    mr = 1'b0;
    req = "R8";  srst = 1'b1; tsel = 1'b1; tcfg = 7'd10; idle(4); srst = 1'b0; idle(130);
    srst = 1'b1; tcfg = 7'd2; idle(4); srst = 1'b0; idle(90);
    srst = 1'b1; tcfg = 7'd120; idle(4); srst = 1'b0; idle(2 * ref_limit(1, 120) + 20);
    req = "R9";  srst = 1'b1; tcfg = 7'd10; idle(4); srst = 1'b0; idle(15);
    tcfg = 7'd50; tsel = 1'b0; idle(150);
    done = 1;
    finish_run();
  end
endmodule